// File: doc/BRIEF.md
# Multi-Queue Transmit Request Scheduler

The block decides which of sixteen circular transmit queues sends its next frame, and to which of eight DMA FIFO channels that frame goes. Each queue is a 256-entry ring. The host moves the write index forward as it posts descriptors. The scheduler owns the read index and steps it forward each time a channel takes a grant. Each queue has a ten-bit status word that holds an active flag, a channel selector, an acknowledged-window mode bit and a window-space flag. A channel may serve several queues.

All configuration arrives on a single host write port. `host_sel` picks the target: 0 is a queue status word, 1 is the channel-enable register, 2 is the queue-empty register, 3 is the chain-mode register, 4 is the read-advance interrupt mask, 5 is a queue write index and 6 is a queue read index. The grant is held in a register and stays put until `gnt_ready`. One cycle after the accept, the queue's read index has advanced and an interrupt pulse may have been raised.

Top module: `txq_sched`

## Requirements
- R1: After reset the grant output is idle, no interrupt bit is set, every queue-empty flag reads 1, and every channel is disabled.
- R2: A status write (`host_sel`=0) uses bits 19:10 of `host_wdata` as write enables for status bits 9:0. A status bit changes only where its enable is 1.
- R3: A queue is eligible when four conditions hold: status bit 0 (active) is 1, its channel is enabled, its write index differs from its read index, and either status bit 8 (acknowledged-window mode) is 0 or status bit 5 (window space) is 1.
- R4: A grant gives the queue number, the queue's read index at the moment the grant was taken, and the channel from status bits 3:1. All of these stay constant while `gnt_ready` is low.
- R5: A cycle with `gnt_valid` and `gnt_ready` both high advances that queue's read index by one, modulo 256, so 255 is followed by 0. `gnt_valid` is low in the next cycle.
- R6: When several channels have eligible queues, the channel is chosen in the fixed order 4, 3, 2, 1, 0, 5, 6, 7, from highest to lowest.
- R7: Queues that share the chosen channel are served round-robin. The search starts at the queue after the one last granted on that channel, and starts at queue 0 if none has been granted yet.
- R8: A queue whose chain-mode bit (`host_sel`=3, one bit per queue) is set, and which was the last one granted on its channel, is granted again while it stays eligible.
- R9: A write to the empty register (`host_sel`=2) updates flag q from bit q only where mask bit 16+q is 1. Each flag is also recomputed as (write index == read index) whenever either index of that queue changes.
- R10: When a grant is accepted for queue q and interrupt mask bit q (`host_sel`=4) is set, `rd_irq[q]` is high for exactly the next cycle.
- R11: The channel-enable register (`host_sel`=1) holds one bit per channel. Writing 0xFF enables all channels. Queues on a disabled channel are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Write target select (see R2 to R11) |
| host_q | input | 4 | Queue number for per-queue targets |
| host_wdata | input | 32 | Write data |
| gnt_ready | input | 1 | The channel takes the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_queue | output | 4 | Granted queue |
| gnt_index | output | 8 | Ring index of the granted frame |
| gnt_chan | output | 3 | Target DMA channel |
| rd_irq | output | 16 | Per-queue read-advance interrupt pulses |
| q_empty | output | 16 | Per-queue empty flags |

## Verification
The bench puts queues on several channels at once and checks the grant order. A rank table that is inverted or missing a channel shows up as a command-channel queue losing to a data queue. Three queues share one channel, each with two frames: a round-robin pointer that does not move, or that moves per cycle rather than per grant, repeats a queue. A chained queue must be granted twice in a row while its neighbour waits, and a design that ignores the chain bit alternates between them. Further checks cover:
- a status write that enables only bit 0, which must leave the channel field intact;
- an acknowledged-window queue that must stay silent until its window-space bit is set;
- a read index at 255 that must wrap to 0 and set the empty flag;
- an empty-register write whose unmasked flags must not move.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

    // Write target selected by host_sel
    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CHEN   = 3'd1,
        SEL_EMPTY  = 3'd2,
        SEL_CHAIN  = 3'd3,
        SEL_IMASK  = 3'd4,
        SEL_WRIDX  = 3'd5,
        SEL_RDIDX  = 3'd6
    } host_sel_e;

    // Status word layout; neighbours decode these positions
    localparam int STAT_W       = 10;
    localparam int STAT_ACTIVE  = 0;
    localparam int STAT_CH_LSB  = 1;
    localparam int STAT_WSPACE  = 5;
    localparam int STAT_ACKWIN  = 8;
    localparam int STAT_EN_LSB  = 10;

    // Empty register layout
    localparam int EMPTY_MASK_LSB = 16;

endpackage

// File: rtl/txq_cfg_regs.sv
module txq_cfg_regs
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int QW     = $clog2(NUM_Q)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [2:0]                     host_sel,
    input  logic [QW-1:0]                  host_q,
    input  logic [31:0]                    host_wdata,
    output logic [NUM_Q-1:0][STAT_W-1:0]   stat,
    output logic [NUM_CH-1:0]              chan_en,
    output logic [NUM_Q-1:0]               chain,
    output logic [NUM_Q-1:0]               imask
);

    typedef struct packed {
        logic [NUM_Q-1:0][STAT_W-1:0] stat;
        logic [NUM_CH-1:0]            chen;
        logic [NUM_Q-1:0]             chain;
        logic [NUM_Q-1:0]             imask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    host_sel_e sel;

    assign sel = host_sel_e'(host_sel);

    always_comb begin
        cfg_d = cfg_q;
        if (host_we) begin
            case (sel)
                SEL_STATUS: begin
                    for (int b = 0; b < STAT_W; b++) begin
                        if (host_wdata[STAT_EN_LSB + b]) begin
                            cfg_d.stat[host_q][b] = host_wdata[b];
                        end
                    end
                end
                SEL_CHEN:  cfg_d.chen  = host_wdata[NUM_CH-1:0];
                SEL_CHAIN: cfg_d.chain = host_wdata[NUM_Q-1:0];
                SEL_IMASK: cfg_d.imask = host_wdata[NUM_Q-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign stat    = cfg_q.stat;
    assign chan_en = cfg_q.chen;
    assign chain   = cfg_q.chain;
    assign imask   = cfg_q.imask;

    // Status bits whose enable was 0 keep their old value
    assert_stat_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == SEL_STATUS) |=>
        ((cfg_q.stat[$past(host_q)] & ~$past(host_wdata[STAT_EN_LSB +: STAT_W])) ==
         ($past(cfg_q.stat[host_q]) & ~$past(host_wdata[STAT_EN_LSB +: STAT_W]))));

endmodule

// File: rtl/txq_ring_ptrs.sv
module txq_ring_ptrs
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int IDX_W = 8,
    parameter int QW    = $clog2(NUM_Q)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [2:0]                    host_sel,
    input  logic [QW-1:0]                 host_q,
    input  logic [31:0]                   host_wdata,
    input  logic                          adv_en,
    input  logic [QW-1:0]                 adv_q,
    output logic [NUM_Q-1:0][IDX_W-1:0]   wr_idx,
    output logic [NUM_Q-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_Q-1:0]              empty
);

    typedef struct packed {
        logic [NUM_Q-1:0][IDX_W-1:0] wr;
        logic [NUM_Q-1:0][IDX_W-1:0] rd;
        logic [NUM_Q-1:0]            empty;
    } ring_t;

    ring_t ring_d, ring_q;
    host_sel_e sel;
    logic [IDX_W-1:0] rd_next;

    assign sel     = host_sel_e'(host_sel);
    assign rd_next = ring_q.rd[adv_q] + 1'b1;

    always_comb begin
        ring_d = ring_q;
        if (host_we && sel == SEL_WRIDX) begin
            ring_d.wr[host_q]    = host_wdata[IDX_W-1:0];
            ring_d.empty[host_q] = (host_wdata[IDX_W-1:0] == ring_q.rd[host_q]);
        end
        if (host_we && sel == SEL_RDIDX) begin
            ring_d.rd[host_q]    = host_wdata[IDX_W-1:0];
            ring_d.empty[host_q] = (host_wdata[IDX_W-1:0] == ring_d.wr[host_q]);
        end
        if (adv_en) begin
            ring_d.rd[adv_q]    = rd_next;
            ring_d.empty[adv_q] = (rd_next == ring_d.wr[adv_q]);
        end
        if (host_we && sel == SEL_EMPTY) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (host_wdata[EMPTY_MASK_LSB + q]) begin
                    ring_d.empty[q] = host_wdata[q];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q.wr    <= '0;
            ring_q.rd    <= '0;
            ring_q.empty <= '1;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign wr_idx = ring_q.wr;
    assign rd_idx = ring_q.rd;
    assign empty  = ring_q.empty;

    // An accepted grant moves the read index forward by exactly one
    assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !(host_we && sel == SEL_RDIDX)) |=>
        (ring_q.rd[$past(adv_q)] == IDX_W'($past(ring_q.rd[adv_q]) + 1'b1)));

endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 8,
    parameter int QW     = $clog2(NUM_Q),
    parameter int CHW    = $clog2(NUM_CH),
    parameter logic [NUM_CH-1:0][CHW-1:0] CH_RANK = '0
) (
    input  logic [NUM_Q-1:0][STAT_W-1:0]  stat,
    input  logic [NUM_CH-1:0]             chan_en,
    input  logic [NUM_Q-1:0]              chain,
    input  logic [NUM_Q-1:0][IDX_W-1:0]   wr_idx,
    input  logic [NUM_Q-1:0][IDX_W-1:0]   rd_idx,
    input  logic [NUM_CH-1:0][QW-1:0]     rr_last,
    input  logic [NUM_CH-1:0]             rr_seen,
    output logic                          pick_valid,
    output logic [QW-1:0]                 pick_q,
    output logic [CHW-1:0]                pick_ch
);

    logic [NUM_Q-1:0][CHW-1:0] q_ch;
    logic [NUM_Q-1:0]          elig;
    logic [NUM_CH-1:0]         ch_pend;
    logic [QW-1:0]             last;
    logic                      keep;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_elig
        assign q_ch[g] = stat[g][STAT_CH_LSB +: CHW];
        assign elig[g] = stat[g][STAT_ACTIVE]
                       & chan_en[q_ch[g]]
                       & (wr_idx[g] != rd_idx[g])
                       & (~stat[g][STAT_ACKWIN] | stat[g][STAT_WSPACE]);
    end

    always_comb begin
        ch_pend = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (elig[q]) ch_pend[q_ch[q]] = 1'b1;
        end
    end

    // Fixed channel rank: entry 0 of CH_RANK is the strongest
    always_comb begin
        pick_ch = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (ch_pend[CH_RANK[k]]) pick_ch = CH_RANK[k];
        end
    end

    assign pick_valid = |ch_pend;
    assign last       = rr_last[pick_ch];
    assign keep       = rr_seen[pick_ch] & chain[last] & elig[last]
                      & (q_ch[last] == pick_ch);

    // Round-robin among queues of the winning channel
    always_comb begin
        pick_q = last;
        for (int i = NUM_Q; i >= 1; i--) begin
            if (elig[(int'(last) + i) % NUM_Q] &&
                q_ch[(int'(last) + i) % NUM_Q] == pick_ch) begin
                pick_q = QW'((int'(last) + i) % NUM_Q);
            end
        end
        if (keep) pick_q = last;
    end

endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_sched_pkg::*;
#(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 8,
    parameter logic [NUM_CH-1:0][$clog2(NUM_CH)-1:0] CH_RANK =
        {3'd7, 3'd6, 3'd5, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [2:0]                host_sel,
    input  logic [$clog2(NUM_Q)-1:0]  host_q,
    input  logic [31:0]               host_wdata,
    input  logic                      gnt_ready,
    output logic                      gnt_valid,
    output logic [$clog2(NUM_Q)-1:0]  gnt_queue,
    output logic [IDX_W-1:0]          gnt_index,
    output logic [$clog2(NUM_CH)-1:0] gnt_chan,
    output logic [NUM_Q-1:0]          rd_irq,
    output logic [NUM_Q-1:0]          q_empty
);

    localparam int QW  = $clog2(NUM_Q);
    localparam int CHW = $clog2(NUM_CH);

    typedef struct packed {
        logic                      valid;
        logic [QW-1:0]             q;
        logic [IDX_W-1:0]          idx;
        logic [CHW-1:0]            ch;
        logic [NUM_Q-1:0]          irq;
        logic [NUM_CH-1:0][QW-1:0] rr_last;
        logic [NUM_CH-1:0]         rr_seen;
    } gnt_t;

    gnt_t st_d, st_q;

    logic [NUM_Q-1:0][STAT_W-1:0] stat;
    logic [NUM_CH-1:0]            chan_en;
    logic [NUM_Q-1:0]             chain;
    logic [NUM_Q-1:0]             imask;
    logic [NUM_Q-1:0][IDX_W-1:0]  wr_idx;
    logic [NUM_Q-1:0][IDX_W-1:0]  rd_idx;
    logic                         pick_valid;
    logic [QW-1:0]                pick_q;
    logic [CHW-1:0]               pick_ch;
    logic                         accept;
    logic [NUM_Q-1:0]             act_vec;

    assign accept = st_q.valid & gnt_ready;

    txq_cfg_regs #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_q(host_q),
        .host_wdata(host_wdata),
        .stat(stat), .chan_en(chan_en), .chain(chain), .imask(imask)
    );

    txq_ring_ptrs #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_q(host_q),
        .host_wdata(host_wdata),
        .adv_en(accept), .adv_q(st_q.q),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .empty(q_empty)
    );

    txq_arbiter #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .IDX_W(IDX_W),
                  .CH_RANK(CH_RANK)) u_arb (
        .stat(stat), .chan_en(chan_en), .chain(chain),
        .wr_idx(wr_idx), .rd_idx(rd_idx),
        .rr_last(st_q.rr_last), .rr_seen(st_q.rr_seen),
        .pick_valid(pick_valid), .pick_q(pick_q), .pick_ch(pick_ch)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        if (accept) begin
            st_d.valid      = 1'b0;
            st_d.irq[st_q.q] = imask[st_q.q];
        end else if (!st_q.valid && pick_valid) begin
            st_d.valid            = 1'b1;
            st_d.q                = pick_q;
            st_d.ch               = pick_ch;
            st_d.idx              = rd_idx[pick_q];
            st_d.rr_last[pick_ch] = pick_q;
            st_d.rr_seen[pick_ch] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rr_last <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid = st_q.valid;
    assign gnt_queue = st_q.q;
    assign gnt_index = st_q.idx;
    assign gnt_chan  = st_q.ch;
    assign rd_irq    = st_q.irq;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_act
        assign act_vec[g] = stat[g][STAT_ACTIVE];
    end

    assert_gnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=>
        (gnt_valid && $stable(gnt_queue) && $stable(gnt_index) && $stable(gnt_chan)));

    assert_gap_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_ready) |=> !gnt_valid);

    assert_gnt_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> ((($past(act_vec) >> gnt_queue) & 1) != 0));

    assert_gnt_chen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> ((($past(chan_en) >> gnt_chan) & 1) != 0));

    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_irq));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_irq != '0) |-> $past(gnt_valid && gnt_ready));

endmodule

// File: tb/txq_sched_bench.sv
`timescale 1ns/1ps
module txq_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [3:0]  host_q = '0;
    logic [31:0] host_wdata = '0;
    logic        gnt_ready = 1'b0;
    logic        gnt_valid;
    logic [3:0]  gnt_queue;
    logic [7:0]  gnt_index;
    logic [2:0]  gnt_chan;
    logic [15:0] rd_irq;
    logic [15:0] q_empty;

    int total = 0;
    int fails = 0;
    logic [7:0] rd_m [16];
    logic [7:0] wr_m [16];

    // {queue[3:0], channel[2:0]}
    localparam logic [6:0] VEC [0:5] = '{7'h00, 7'h2B, 7'h4C, 7'h7F, 7'h3A, 7'h1D};

    always #4 clk = ~clk;

    txq_sched u_txq_sched (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_q(host_q), .host_wdata(host_wdata), .gnt_ready(gnt_ready),
        .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .gnt_index(gnt_index),
        .gnt_chan(gnt_chan), .rd_irq(rd_irq), .q_empty(q_empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hwrite(input int sel, input int q, input logic [31:0] d);
        host_we = 1'b1; host_sel = 3'(sel); host_q = 4'(q); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_status(input int q, input logic [9:0] en, input logic [9:0] val);
        hwrite(0, q, {12'd0, en, val});
    endtask

    task automatic post(input int q, input int n);
        wr_m[q] = wr_m[q] + 8'(n);
        hwrite(5, q, {24'd0, wr_m[q]});
    endtask

    task automatic take(input int q, input int ch, input string tag);
        int w;
        w = 0;
        while (!gnt_valid && w < 30) begin
            @(negedge clk);
            w++;
        end
        check(gnt_valid === 1'b1, {tag, " valid"}, int'(gnt_valid), 1);
        check(gnt_queue == 4'(q), {tag, " queue"}, int'(gnt_queue), q);
        check(gnt_chan == 3'(ch), {tag, " chan"}, int'(gnt_chan), ch);
        check(gnt_index == rd_m[q], {tag, " index"}, int'(gnt_index), int'(rd_m[q]));
        gnt_ready = 1'b1;
        @(negedge clk);
        gnt_ready = 1'b0;
        rd_m[q] = rd_m[q] + 8'd1;
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (gnt_valid) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rd_m[i] = '0;
            wr_m[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(gnt_valid == 1'b0, "R1 gnt idle", int'(gnt_valid), 0);
        check(rd_irq == '0, "R1 irq clear", int'(rd_irq), 0);
        check(q_empty == 16'hFFFF, "R1 empty flags", int'(q_empty), 16'hFFFF);
        set_status(2, 10'h3FF, 10'h001);
        post(2, 1);
        quiet(8, "R1 channels disabled after reset");
        set_status(2, 10'h001, 10'h000);
        hwrite(1, 0, 32'h0000_00FF);
        // queue 2 is inactive now; its pending frame stays unsent
        quiet(6, "R3 inactive queue not granted");
        wr_m[2] = rd_m[2];
        hwrite(5, 2, {24'd0, wr_m[2]});

        // Table walk: R3 R4 R5 single queue on each channel
        for (int v = 0; v < 6; v++) begin
            int q;
            int ch;
            q  = int'(VEC[v][6:3]);
            ch = int'(VEC[v][2:0]);
            set_status(q, 10'h3FF, {6'd0, 3'(ch), 1'b1});
            post(q, 1);
            check(q_empty[q] == 1'b0, "R9 empty clears on post", int'(q_empty[q]), 0);
            take(q, ch, "R4 table grant");
            check(q_empty[q] == 1'b1, "R9 empty sets when drained", int'(q_empty[q]), 1);
            check(gnt_valid == 1'b0, "R5 gap after accept", int'(gnt_valid), 0);
            set_status(q, 10'h001, 10'h000);
        end

        // R2 masked status write keeps the channel field
        set_status(5, 10'h001, 10'h001);
        post(5, 1);
        take(5, 3, "R2 channel kept");
        set_status(5, 10'h001, 10'h000);

        // R6 channel rank
        hwrite(1, 0, 32'h0);
        set_status(1, 10'h3FF, 10'h001);
        set_status(2, 10'h3FF, 10'h007);
        set_status(6, 10'h3FF, 10'h009);
        set_status(8, 10'h3FF, 10'h00B);
        post(1, 1); post(2, 1); post(6, 1); post(8, 1);
        hwrite(1, 0, 32'hFF);
        take(6, 4, "R6 rank first");
        take(2, 3, "R6 rank second");
        take(1, 0, "R6 rank third");
        take(8, 5, "R6 rank fourth");

        // R7 round-robin on channel 1
        hwrite(1, 0, 32'h0);
        for (int q = 10; q <= 12; q++) begin
            set_status(q, 10'h3FF, 10'h003);
            post(q, 2);
        end
        hwrite(1, 0, 32'hFF);
        for (int r = 0; r < 2; r++) begin
            take(10, 1, "R7 rr q10");
            take(11, 1, "R7 rr q11");
            take(12, 1, "R7 rr q12");
        end

        // R8 chain mode on queue 13, channel 6
        hwrite(1, 0, 32'h0);
        hwrite(3, 0, 32'h0000_2000);
        set_status(13, 10'h3FF, 10'h00D);
        set_status(14, 10'h3FF, 10'h00D);
        post(13, 2); post(14, 2);
        hwrite(1, 0, 32'hFF);
        take(13, 6, "R8 chain first");
        take(13, 6, "R8 chain repeat");
        take(14, 6, "R8 after chain");
        take(14, 6, "R8 after chain 2");
        hwrite(3, 0, 32'h0);

        // R11 channel enable
        hwrite(1, 0, 32'hEF);
        set_status(4, 10'h3FF, 10'h009);
        post(4, 1);
        quiet(10, "R11 disabled channel");
        hwrite(1, 0, 32'hFF);
        take(4, 4, "R11 enabled channel");

        // R3 ack-window queue waits for window space; R10 irq
        set_status(9, 10'h3FF, 10'h109);
        post(9, 1);
        quiet(10, "R3 no window space");
        hwrite(4, 0, 32'h0000_0200);
        set_status(9, 10'h020, 10'h020);
        take(9, 4, "R3 window space granted");
        check(rd_irq == 16'h0200, "R10 irq pulse", int'(rd_irq), 16'h0200);
        @(negedge clk);
        check(rd_irq == 16'h0000, "R10 irq single cycle", int'(rd_irq), 0);
        set_status(4, 10'h3FF, 10'h009);
        post(4, 1);
        take(4, 4, "R10 unmasked queue");
        check(rd_irq == 16'h0000, "R10 masked off no irq", int'(rd_irq), 0);

        // R5 wrap at 255, R9 empty flags
        rd_m[0] = 8'd255;
        hwrite(6, 0, 32'd255);
        wr_m[0] = 8'd0;
        hwrite(5, 0, 32'd0);
        check(q_empty[0] == 1'b0, "R9 empty after index writes", int'(q_empty[0]), 0);
        set_status(0, 10'h001, 10'h001);
        take(0, 0, "R5 index 255");
        check(q_empty[0] == 1'b1, "R5 wrap to 0 empties", int'(q_empty[0]), 1);
        set_status(0, 10'h001, 10'h000);
        hwrite(2, 0, 32'h0005_0002);
        check(q_empty[0] == 1'b0, "R9 masked flag q0", int'(q_empty[0]), 0);
        check(q_empty[1] == 1'b1, "R9 unmasked flag q1", int'(q_empty[1]), 1);
        check(q_empty[2] == 1'b0, "R9 masked flag q2", int'(q_empty[2]), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule